// File: doc/BRIEF.md
# Atomic 16-bit Access Bridge

This block sits between an 8-bit processor register bus and a group of 16-bit peripheral registers. Entry 0 is a free-running counter and entries 1 and 2 are compare values. Software has to reach each 16-bit quantity through two byte accesses. A single shared temporary byte makes each pair of accesses behave as one atomic 16-bit transfer.

For writes, the high byte goes first and only loads the temporary byte. The low byte then joins the temporary byte and is committed to the target as a one-cycle write strobe with a 16-bit value. For counter reads, the low byte goes first. It returns the live low byte and, in the same cycle, latches the live high byte into the temporary byte. A later high-byte read returns that snapshot. Compare registers are read directly on both bytes.

The peripherals themselves (counting, compare logic, storage) are outside this block. The peripherals return their current values on `reg_live` and take updates from `reg_wr_stb` and `reg_wr_data`.

A small state machine records what last loaded the temporary byte. It has three states:
- `TMP_CLEAR`: the state after reset.
- `TMP_WR_HELD`: the byte came from a high-byte write.
- `TMP_RD_HELD`: the byte came from a counter snapshot.

It has two transitions, each taken from any state:
- `load_from_write` enters `TMP_WR_HELD`.
- `load_from_read` enters `TMP_RD_HELD`.

When neither event happens, the state holds.

Top module: `atomic16_bridge`

## Requirements
- R1: After reset the temporary byte is 0x00. A counter high-byte read (address 0x0) with no earlier low read returns 0x00. A low-byte write with no earlier high write commits 0x00 as the upper half. All write strobes and the capture strobe are 0.
- R2: A write to an even address 0x0, 0x2 or 0x4 (high byte of entry addr/2) asserts no write strobe and only stores the data byte in the temporary byte.
- R3: A write to an odd address 0x1, 0x3 or 0x5 (low byte of entry addr/2) asserts bit addr/2 of `reg_wr_stb`, and only that bit, in the same cycle. `reg_wr_data` = {temporary byte, written byte} in that cycle.
- R4: A read of address 0x1 returns `reg_live[0][7:0]` in the same cycle and asserts `cnt_capture`. At that clock edge the temporary byte takes `reg_live[0][15:8]`.
- R5: A read of address 0x0 returns the temporary byte, not the live counter high byte.
- R6: Reads of addresses 0x2/0x3 and 0x4/0x5 return the high and low byte of `reg_live[1]` and `reg_live[2]` directly, and leave the temporary byte unchanged.
- R7: The temporary byte is shared. A high write to one entry followed by a low write to a different entry commits the stale byte as the upper half of the second entry.
- R8: Reads and writes share the temporary byte. A counter low read replaces a byte left by a high write, and a high write replaces a counter snapshot.
- R9: Accesses to unmapped addresses 0x6 and 0x7 assert no strobe, read as 0x00 and leave the temporary byte unchanged.
- R10: When `bus_wr` and `bus_rd` are both high, the write is performed and the read is ignored. No capture strobe is asserted and the temporary byte is not loaded by the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Byte address |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_rd | input | 1 | Read enable for this cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| reg_live | input | 3x16 | Current value of each 16-bit entry |
| reg_wr_stb | output | 3 | One-cycle write strobe per entry |
| reg_wr_data | output | 16 | Combined 16-bit value for the strobed entry |
| cnt_capture | output | 1 | Counter low-byte read, snapshot taken this cycle |

## Verification
The bench builds the block with its defaults: three entries, with only entry 0 using the latched read. At this size every mapped address and both unmapped ones can be driven with a sweep of byte patterns whose expected results are simple arithmetic. The sweep commits sixteen value pairs into each entry and takes sixteen counter snapshots while the live value changes between the two reads. Because there is only one temporary byte, every cross-entry and read-versus-write interleaving of it is also within reach.

// File: rtl/atomic16_pkg.sv
package atomic16_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        TMP_CLEAR   = 2'd0,
        TMP_WR_HELD = 2'd1,
        TMP_RD_HELD = 2'd2
    } tmp_src_e;
endpackage

// File: rtl/atomic16_decode.sv
module atomic16_decode #(
    parameter int NUM_REGS    = 3,
    parameter int ADDR_W      = 3,
    parameter logic [NUM_REGS-1:0] LATCH_MASK = 1
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic                rd,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit,
    output logic                high_byte,
    output logic                wr_high,
    output logic                wr_low,
    output logic                rd_snap
);
    logic [NUM_REGS-1:0] latched_sel;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        assign sel[i]         = (addr[ADDR_W-1:1] == (ADDR_W-1)'(i));
        assign latched_sel[i] = sel[i] & LATCH_MASK[i];
    end

    always_comb begin
        hit       = |sel;
        high_byte = ~addr[0];
        wr_high   = wr & hit & high_byte;
        wr_low    = wr & hit & ~high_byte;
        rd_snap   = rd & ~wr & ~high_byte & (|latched_sel);
    end
endmodule

// File: rtl/atomic16_temp.sv
module atomic16_temp
    import atomic16_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_from_write,
    input  logic [BYTE_W-1:0] write_byte,
    input  logic              load_from_read,
    input  logic [BYTE_W-1:0] snap_byte,
    output logic [BYTE_W-1:0] tmp_q,
    output tmp_src_e          state_q
);
    tmp_src_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMP_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMP_CLEAR, TMP_WR_HELD, TMP_RD_HELD: begin
                if (load_from_write) begin
                    state_d = TMP_WR_HELD;
                end else if (load_from_read) begin
                    state_d = TMP_RD_HELD;
                end
            end
            default: state_d = TMP_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q <= '0;
        end else if (load_from_write) begin
            tmp_q <= write_byte;
        end else if (load_from_read) begin
            tmp_q <= snap_byte;
        end
    end
endmodule

// File: rtl/atomic16_rdmux.sv
module atomic16_rdmux
    import atomic16_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter logic [NUM_REGS-1:0] LATCH_MASK = 1
) (
    input  logic [NUM_REGS-1:0]             sel,
    input  logic                            high_byte,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] live,
    input  logic [BYTE_W-1:0]               tmp,
    output logic [BYTE_W-1:0]               rdata
);
    logic [NUM_REGS-1:0][BYTE_W-1:0] per_reg;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
        if (LATCH_MASK[i]) begin : g_latched
            assign per_reg[i] = high_byte ? tmp : live[i][BYTE_W-1:0];
        end else begin : g_direct
            assign per_reg[i] = high_byte ? live[i][WORD_W-1:BYTE_W]
                                          : live[i][BYTE_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rdata = rdata | (per_reg[i] & {BYTE_W{sel[i]}});
        end
    end
endmodule

// File: rtl/atomic16_bridge.sv
module atomic16_bridge
    import atomic16_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter logic [NUM_REGS-1:0] LATCH_MASK = 1,
    localparam int ADDR_W = $clog2(2 * NUM_REGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic                            bus_wr,
    input  logic                            bus_rd,
    input  logic [BYTE_W-1:0]               bus_wdata,
    output logic [BYTE_W-1:0]               bus_rdata,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] reg_live,
    output logic [NUM_REGS-1:0]             reg_wr_stb,
    output logic [WORD_W-1:0]               reg_wr_data,
    output logic                            cnt_capture
);
    logic [NUM_REGS-1:0] sel;
    logic                hit, high_byte, wr_high, wr_low, rd_snap;
    logic [BYTE_W-1:0]   tmp_q, snap_byte, mux_data;
    tmp_src_e            tmp_src;

    atomic16_decode #(
        .NUM_REGS  (NUM_REGS),
        .ADDR_W    (ADDR_W),
        .LATCH_MASK(LATCH_MASK)
    ) u_decode (
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .sel      (sel),
        .hit      (hit),
        .high_byte(high_byte),
        .wr_high  (wr_high),
        .wr_low   (wr_low),
        .rd_snap  (rd_snap)
    );

    always_comb begin
        snap_byte = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                snap_byte = reg_live[i][WORD_W-1:BYTE_W];
            end
        end
    end

    atomic16_temp u_temp (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_from_write(wr_high),
        .write_byte     (bus_wdata),
        .load_from_read (rd_snap),
        .snap_byte      (snap_byte),
        .tmp_q          (tmp_q),
        .state_q        (tmp_src)
    );

    atomic16_rdmux #(
        .NUM_REGS  (NUM_REGS),
        .LATCH_MASK(LATCH_MASK)
    ) u_rdmux (
        .sel      (sel),
        .high_byte(high_byte),
        .live     (reg_live),
        .tmp      (tmp_q),
        .rdata    (mux_data)
    );

    always_comb begin
        bus_rdata   = (bus_rd && hit) ? mux_data : '0;
        reg_wr_stb  = wr_low ? sel : '0;
        reg_wr_data = {tmp_q, bus_wdata};
        cnt_capture = rd_snap;
    end
endmodule

// File: rtl/atomic16_bridge_chk.sv
module atomic16_bridge_chk
    import atomic16_pkg::*;
#(
    parameter int NUM_REGS = 3,
    parameter int ADDR_W   = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               bus_addr,
    input logic                            bus_wr,
    input logic                            bus_rd,
    input logic [BYTE_W-1:0]               bus_wdata,
    input logic [BYTE_W-1:0]               bus_rdata,
    input logic [NUM_REGS-1:0][WORD_W-1:0] reg_live,
    input logic [NUM_REGS-1:0]             reg_wr_stb,
    input logic [WORD_W-1:0]               reg_wr_data,
    input logic                            cnt_capture,
    input tmp_src_e                        tmp_src
);
    logic mapped;
    assign mapped = (int'(bus_addr) < 2 * NUM_REGS);

    // R2
    high_write_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr[0]) |-> (reg_wr_stb == '0));

    // R3
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wr_stb));

    // R3
    low_byte_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_stb != '0) |-> (reg_wr_data[BYTE_W-1:0] == bus_wdata));

    // R7
    pair_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && mapped && !bus_addr[0]) |=>
        ((bus_wr && mapped && bus_addr[0]) |->
         (reg_wr_data[WORD_W-1:BYTE_W] == $past(bus_wdata))));

    // R5
    snapshot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == 1) |=>
        ((bus_rd && bus_addr == 0) |->
         (bus_rdata == $past(reg_live[0][WORD_W-1:BYTE_W]))));

    // R4
    capture_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_capture |=> (tmp_src == TMP_RD_HELD));

    // R9
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (reg_wr_stb == '0 && bus_rdata == '0 && !cnt_capture));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !cnt_capture);
endmodule

bind atomic16_bridge atomic16_bridge_chk #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .reg_live   (reg_live),
    .reg_wr_stb (reg_wr_stb),
    .reg_wr_data(reg_wr_data),
    .cnt_capture(cnt_capture),
    .tmp_src    (tmp_src)
);

// File: tb/atomic16_bridge_bench.sv
module atomic16_bridge_bench;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       bus_addr = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic [2:0][15:0] reg_live = '0;
    logic [2:0]       reg_wr_stb;
    logic [15:0]      reg_wr_data;
    logic             cnt_capture;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    atomic16_bridge u_atomic16_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .reg_live   (reg_live),
        .reg_wr_stb (reg_wr_stb),
        .reg_wr_data(reg_wr_data),
        .cnt_capture(cnt_capture)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one bus cycle at the falling edge; outputs settle 2 ns later
    task automatic drive(input bit wr, input bit rd, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #2;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  hi, lo;
        logic [15:0] live, other;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #2;
        chk(reg_wr_stb == 3'b000, "R1 strobes idle", 32'(reg_wr_stb), 0);
        chk(cnt_capture == 1'b0, "R1 capture idle", 32'(cnt_capture), 0);
        reg_live[0] = 16'hA1B2;
        drive(1'b0, 1'b1, 3'd0, 8'h00);
        chk(bus_rdata == 8'h00, "R1 temp reset", 32'(bus_rdata), 0);
        drive(1'b1, 1'b0, 3'd3, 8'h42);
        chk(reg_wr_stb == 3'b010 && reg_wr_data == 16'h0042, "R1 low write after reset",
            32'(reg_wr_data), 32'h0042);

        // R2 / R3 sweep over all entries
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 16; k++) begin
                hi = 8'(k * 17);
                lo = 8'(k * 29 + r * 7);
                drive(1'b1, 1'b0, 3'(2 * r), hi);
                chk(reg_wr_stb == 3'b000, "R2 high write no strobe", 32'(reg_wr_stb), 0);
                drive(1'b1, 1'b0, 3'(2 * r + 1), lo);
                chk(reg_wr_stb == 3'(1 << r), "R3 strobe select", 32'(reg_wr_stb), 32'(1 << r));
                chk(reg_wr_data == {hi, lo}, "R3 combined data", 32'(reg_wr_data), 32'({hi, lo}));
            end
        end

        // R4 / R5 counter snapshot sweep
        for (int k = 0; k < 16; k++) begin
            live  = 16'(k * 4099 + 16'h1234);
            other = ~live;
            reg_live[0] = live;
            drive(1'b0, 1'b1, 3'd1, 8'h00);
            chk(bus_rdata == live[7:0], "R4 live low byte", 32'(bus_rdata), 32'(live[7:0]));
            chk(cnt_capture == 1'b1, "R4 capture strobe", 32'(cnt_capture), 1);
            idle();
            reg_live[0] = other;
            drive(1'b0, 1'b1, 3'd0, 8'h00);
            chk(bus_rdata == live[15:8], "R5 snapshot high byte", 32'(bus_rdata), 32'(live[15:8]));
        end

        // R6 compare entries read directly
        reg_live[1] = 16'hC3D4;
        reg_live[2] = 16'h5E6F;
        drive(1'b0, 1'b1, 3'd2, 8'h00);
        chk(bus_rdata == 8'hC3, "R6 entry1 high", 32'(bus_rdata), 32'hC3);
        drive(1'b0, 1'b1, 3'd3, 8'h00);
        chk(bus_rdata == 8'hD4, "R6 entry1 low", 32'(bus_rdata), 32'hD4);
        drive(1'b0, 1'b1, 3'd4, 8'h00);
        chk(bus_rdata == 8'h5E, "R6 entry2 high", 32'(bus_rdata), 32'h5E);
        drive(1'b0, 1'b1, 3'd5, 8'h00);
        chk(bus_rdata == 8'h6F && cnt_capture == 1'b0, "R6 entry2 low", 32'(bus_rdata), 32'h6F);
        drive(1'b0, 1'b1, 3'd0, 8'h00);
        chk(bus_rdata == live[15:8], "R6 temp untouched", 32'(bus_rdata), 32'(live[15:8]));

        // R7 stale shared temp across entries
        drive(1'b1, 1'b0, 3'd2, 8'h5A);
        drive(1'b1, 1'b0, 3'd5, 8'h3C);
        chk(reg_wr_stb == 3'b100 && reg_wr_data == 16'h5A3C, "R7 cross-entry commit",
            32'(reg_wr_data), 32'h5A3C);

        // R8 read and write share the temp byte
        reg_live[0] = 16'hBEEF;
        drive(1'b0, 1'b1, 3'd1, 8'h00);
        drive(1'b1, 1'b0, 3'd3, 8'h11);
        chk(reg_wr_data == 16'hBE11, "R8 snapshot used by write", 32'(reg_wr_data), 32'hBE11);
        drive(1'b1, 1'b0, 3'd0, 8'h77);
        drive(1'b0, 1'b1, 3'd0, 8'h00);
        chk(bus_rdata == 8'h77, "R8 write replaces snapshot", 32'(bus_rdata), 32'h77);

        // R9 unmapped addresses
        drive(1'b1, 1'b0, 3'd6, 8'h99);
        chk(reg_wr_stb == 3'b000, "R9 unmapped write", 32'(reg_wr_stb), 0);
        drive(1'b1, 1'b0, 3'd7, 8'h98);
        chk(reg_wr_stb == 3'b000, "R9 unmapped write odd", 32'(reg_wr_stb), 0);
        drive(1'b0, 1'b1, 3'd7, 8'h00);
        chk(bus_rdata == 8'h00 && cnt_capture == 1'b0, "R9 unmapped read", 32'(bus_rdata), 0);
        drive(1'b0, 1'b1, 3'd0, 8'h00);
        chk(bus_rdata == 8'h77, "R9 temp unchanged", 32'(bus_rdata), 32'h77);

        // R10 simultaneous read and write
        reg_live[0] = 16'h2468;
        drive(1'b1, 1'b1, 3'd1, 8'h55);
        chk(reg_wr_stb == 3'b001 && reg_wr_data == 16'h7755, "R10 write performed",
            32'(reg_wr_data), 32'h7755);
        chk(cnt_capture == 1'b0, "R10 no capture", 32'(cnt_capture), 0);
        drive(1'b0, 1'b1, 3'd0, 8'h00);
        chk(bus_rdata == 8'h77, "R10 temp not loaded", 32'(bus_rdata), 32'h77);

        idle();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule